// File: doc/BRIEF.md
# Reloading Countdown Timer

This block is a per-core countdown timer that software programs through four 32-bit word registers. Software writes an interval into the reload register, and that write also copies the interval into the live counter. The counter then steps down by one on each clock while the run bit is set. When it expires, the block sets a sticky event flag. If the interrupt-enable bit is set, the flag drives the interrupt line.

The repeat bit decides what happens after expiry. With the bit set, the counter takes the reload value again in the expiry cycle, which gives a periodic tick whose period is the reload value in clocks. With the bit clear, the counter parks at zero and raises no further events until software loads a new interval. The interrupt line follows the sticky flag. Software clears the flag by writing 1 to the status word, and the next expiry then produces a fresh rising edge for an edge-sampling interrupt controller.

Top module: `rcd_timer`

## Requirements
- R1: After reset, every register (reload, counter, control and flag) reads zero and irq is low.
- R2: Reads decode byte address bits [3:2] and are combinational. 0x0 returns the reload value. 0x4 returns the live counter. 0x8 returns the control word, with run in bit 0, repeat in bit 1, interrupt enable in bit 2 and zeros above. 0xC returns the event flag in bit 0 and zeros above.
- R3: A write to 0x0 stores the reload value and puts the same value in the counter at that clock edge. This holds even while the timer runs, and the write takes priority over a decrement or an expiry in the same cycle.
- R4: While run is set, a non-zero counter above one decreases by exactly one per clock. While run is clear, the counter holds its value.
- R5: An expiry happens when run is set, no reload write is in progress and the counter holds 1. An expiry sets the event flag at the same edge. A running counter at 0 causes no event.
- R6: With repeat set, the counter takes the reload value at the expiry edge. A reload value of N therefore gives one expiry every N clocks.
- R7: With repeat clear, the counter becomes 0 at expiry and stays at 0 while running.
- R8: The event flag is sticky. Writing 0xC with bit 0 set clears it, and writing 0 to that bit leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R9: irq is high exactly when the event flag and the interrupt-enable bit (control bit 2) are both set. Each expiry after a clear raises irq again.
- R10: Writes to the counter address 0x4 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 4 | Byte address of the accessed word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach from the ports is a status clear that arrives at exactly the same edge as an expiry. It only happens if the write is placed on the one clock where the counter passes 1. The stimulus disables the timer, loads a small interval and starts it in periodic mode. It counts the edges from the enabling write, then issues the clear so that it lands on the expiry edge, and reads the flag back as set. The bench also counts edges to check the periodic reload spacing, and it checks a reload write landing in the middle of a run.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned WSEL_LSB = 2;

  typedef enum logic [1:0] {
    WSEL_RELOAD = 2'd0,
    WSEL_COUNT  = 2'd1,
    WSEL_CTRL   = 2'd2,
    WSEL_STAT   = 2'd3
  } wsel_e;

  // control word layout: run in bit 0, repeat in bit 1, irq enable in bit 2
  typedef struct packed {
    logic irq_en;
    logic repeat_en;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rcd_rst_sync.sv
`timescale 1ns/1ps
module rcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rcd_regfile.sv
`timescale 1ns/1ps
module rcd_regfile
  import rcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              reload_wr,
  output logic [DATA_W-1:0] reload_q,
  output ctrl_t             ctrl_q,
  output logic              flag_q
);
  wsel_e       wsel;
  logic        ctrl_wr;
  logic        flag_clr;
  logic        flag_d;
  logic        flag_en;
  ctrl_t       ctrl_d;

  assign wsel      = wsel_e'(addr[WSEL_LSB +: 2]);
  assign reload_wr = wr_en && (wsel == WSEL_RELOAD);
  assign ctrl_wr   = wr_en && (wsel == WSEL_CTRL);
  assign flag_clr  = wr_en && (wsel == WSEL_STAT) && wdata[0];
  assign ctrl_d    = ctrl_t'(wdata[CTRL_W-1:0]);

  // set beats clear so an expiry is never lost
  always_comb begin
    flag_d = flag_q;
    if (expire)        flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end
  assign flag_en = expire | flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));
endmodule

// File: rtl/rcd_counter.sv
`timescale 1ns/1ps
module rcd_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             repeat_en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             at_one;
  logic             at_zero;

  assign at_one  = (count_q == ONE);
  assign at_zero = (count_q == '0);
  assign expire  = run && !load_wr && at_one;

  always_comb begin
    count_d = count_q;
    if (load_wr)               count_d = load_val;
    else if (run && at_one)    count_d = repeat_en ? reload_val : '0;
    else if (run && !at_zero)  count_d = count_q - ONE;
  end
  assign count_en = load_wr | run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_q == $past(load_val));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load_wr |=> $stable(count_q));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_wr && (count_q > ONE) |=> count_q == $past(count_q) - ONE);

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && repeat_en |=> count_q == $past(reload_val));

  // R7
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !repeat_en && !load_wr && (count_q <= ONE) |=> count_q == '0);
endmodule

// File: rtl/rcd_readmux.sv
`timescale 1ns/1ps
module rcd_readmux
  import rcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reload_q,
  input  logic [DATA_W-1:0] count_q,
  input  ctrl_t             ctrl_q,
  input  logic              flag_q,
  output logic [DATA_W-1:0] rdata
);
  wsel_e wsel;
  assign wsel = wsel_e'(addr[WSEL_LSB +: 2]);

  always_comb begin
    rdata = '0;
    unique case (wsel)
      WSEL_RELOAD: rdata = reload_q;
      WSEL_COUNT:  rdata = count_q;
      WSEL_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      WSEL_STAT:   rdata[0] = flag_q;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/rcd_timer.sv
`timescale 1ns/1ps
module rcd_timer
  import rcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              rst_sync_n;
  logic              reload_wr;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  ctrl_t             ctrl_q;
  logic              flag_q;
  logic              expire;

  rcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rcd_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .expire    (expire),
    .reload_wr (reload_wr),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .flag_q    (flag_q)
  );

  rcd_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (ctrl_q.run),
    .repeat_en  (ctrl_q.repeat_en),
    .load_wr    (reload_wr),
    .load_val   (wdata),
    .reload_val (reload_q),
    .count_q    (count_q),
    .expire     (expire)
  );

  rcd_readmux #(.DATA_W(DATA_W)) u_rd (
    .addr     (addr),
    .reload_q (reload_q),
    .count_q  (count_q),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q),
    .rdata    (rdata)
  );

  assign irq = flag_q & ctrl_q.irq_en;

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> ctrl_q.irq_en && ($past(expire) || $rose(ctrl_q.irq_en)));
endmodule

// File: tb/rcd_timer_bench.sv
`timescale 1ns/1ps
module rcd_timer_bench;
  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        chk_vld = 1'b0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  item_t       sb_q[$];

  always #2 clk = ~clk;

  rcd_timer u_rcd_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (chk_vld && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", it.req, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.req = req;
    addr = a;
    sb_q.push_back(it);
    chk_vld = 1'b1;
    @(negedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = req;
    sb_q.push_back(it);
    chk_vld = 1'b1;
    @(negedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk(4'h0, 32'h0, "R1 reload");
    chk(4'h4, 32'h0, "R1 counter");
    chk(4'h8, 32'h0, "R1 control");
    chk(4'hC, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    // R2 R3 load while stopped
    wr(4'h0, 32'd5);
    chk(4'h0, 32'd5, "R2 reload readback");
    chk(4'h4, 32'd5, "R3 load copies to counter");
    // R10 counter address ignores writes
    wr(4'h4, 32'h77);
    chk(4'h4, 32'd5, "R10 counter write ignored");
    // R4 holds while run clear
    step(3);
    chk(4'h4, 32'd5, "R4 hold while stopped");

    // R4 decrement
    wr(4'h0, 32'd100);
    wr(4'h8, 32'h1);
    chk(4'h4, 32'd100, "R4 first cycle after enable");
    chk(4'h4, 32'd99, "R4 one step");
    chk(4'h8, 32'h1, "R2 control readback");
    wr(4'h8, 32'h0);
    chk(4'h4, 32'd97, "R4 frozen after disable");

    // one-shot expiry R5 R7
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h1);
    step(2);
    chk(4'hC, 32'h0, "R5 no flag before expiry");
    chk(4'hC, 32'h1, "R5 flag at expiry");
    chk(4'h4, 32'h0, "R7 parked at zero");
    step(5);
    chk(4'h4, 32'h0, "R7 still zero");
    chk(4'hC, 32'h1, "R8 flag sticky");
    chk_irq(1'b0, "R9 irq gated by enable");
    wr(4'h8, 32'h5);
    chk_irq(1'b1, "R9 irq with enable");
    wr(4'hC, 32'h0);
    chk(4'hC, 32'h1, "R8 write zero keeps flag");
    wr(4'hC, 32'h1);
    chk(4'hC, 32'h0, "R8 write one clears");
    chk_irq(1'b0, "R9 irq drops on clear");
    step(4);
    chk(4'hC, 32'h0, "R5 zero counter gives no event");

    // periodic R6 R9
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd4);
    wr(4'h8, 32'h7);
    step(3);
    chk(4'h4, 32'd1, "R6 before expiry");
    chk(4'h4, 32'd4, "R6 reloaded at expiry");
    chk(4'hC, 32'h1, "R6 flag on periodic expiry");
    chk_irq(1'b1, "R9 irq periodic");
    wr(4'hC, 32'h1);
    chk_irq(1'b0, "R9 cleared");
    chk_irq(1'b1, "R9 new rising edge next expiry");
    chk(4'h4, 32'd3, "R6 period of four");

    // R3 load while running
    wr(4'h0, 32'd50);
    chk(4'h4, 32'd50, "R3 load while running");
    chk(4'h0, 32'd50, "R3 reload updated");
    chk(4'h4, 32'd48, "R3 counting from new value");

    // R8 clear on the expiry edge
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h1);
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h3);
    step(2);
    wr(4'hC, 32'h1);
    chk(4'hC, 32'h1, "R8 expiry wins over clear");
    chk(4'h4, 32'd2, "R6 reload after contested edge");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule